// File: doc/BRIEF.md
# Randomized Two-Pass Result Release Checker

This block makes the last decision of a protected cipher: it either lets the finished ciphertext go out or orders the key store to be wiped. It does this by comparing each of the sixteen final check bytes against a precomputed expected byte. The comparisons do not run in a fixed order. A per-device schedule assigns a byte index to each of sixteen time slots. Each slot also has a per-device polarity bit, which decides whether the raw condition is formed as "bytes equal" or as "bytes differ".

The condition is never used as a branch. It is spread into a mask, and that mask merges two action codes arithmetically, so the selected code is correct under either polarity. Any result other than the pass code counts as a detection. The whole sequence runs twice, and the second pass uses its own schedule and its own polarity bits. The ciphertext is released only after both passes have finished with no detection.

Every detection latches a sticky delete-key output. Every detection also raises a saturating tamper count. When that count reaches a programmable limit, the block locks itself until reset.

Top module: `result_gate_top`

## Requirements
- R1: During and after reset, `releaseOut`, `deleteKey`, `done`, `busy` and `locked` are all low, and the tamper count is zero.
- R2: A `start` pulse is accepted only when the block is idle and not locked. `busy` goes high in the next cycle and stays high for exactly 32 cycles: 16 slots of pass 0, then 16 slots of pass 1.
- R3: In slot j of pass p, the byte checked is the one whose index is held in `permCfg[(p*16+j)*4 +: 4]`. Check byte k sits at `checkData[k*8 +: 8]` and its expected value at `expectData[k*8 +: 8]`. A byte that no slot selects is never checked.
- R4: A slot check detects a fault exactly when the checked byte differs from its expected byte. The polarity bit `polCfg[p*16+j]` (1 = equality form, 0 = inequality form) does not change the outcome.
- R5: A detection drives `deleteKey` high from the cycle after that slot. `deleteKey` stays high until reset.
- R6: `done` is a one-cycle pulse in the cycle after the last slot of pass 1. `busy` is low in that cycle.
- R7: `releaseOut` rises together with `done` only when neither pass detected a fault and `deleteKey` was low. It stays high until the next accepted `start`.
- R8: A mismatch that only the pass 1 schedule visits still blocks release, because the two passes use independent schedules.
- R9: Each detecting slot adds one to an 8-bit saturating tamper count. When the count reaches `tamperLimit` (a limit of 0 acts as 1), `locked` goes high in the cycle after that slot. `locked` stays high until reset, and `start` is ignored while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a two-pass check sequence |
| checkData | input | 128 | Sixteen final check bytes, byte k at bits k*8+7..k*8 |
| expectData | input | 128 | Sixteen expected bytes, same layout |
| permCfg | input | 128 | Per-device slot schedule, one 4-bit byte index per slot, pass 0 in the low half |
| polCfg | input | 32 | Per-slot comparison polarity, pass 0 in the low half |
| tamperLimit | input | 8 | Detections allowed before lock-out |
| busy | output | 1 | Check sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| releaseOut | output | 1 | Ciphertext may be released |
| deleteKey | output | 1 | Sticky order to wipe the key |
| locked | output | 1 | Block permanently disabled |

## Verification
The block is tried with fully matching bytes under an identity schedule and under mixed polarity words. A result that differs between the two would mean the polarity leaked into the verdict. A single mismatch under a reversed schedule shows detection and the sticky delete. Schedules that never visit the corrupted byte in one pass or in both passes tell apart a correct per-slot index lookup from one that checks every byte or ignores the second pass. Repeated detections against limits of 2 and 0 separate correct counting, the zero-limit rule and the ignored start after lock-out.

// File: rtl/result_gate_pkg.sv
package result_gate_pkg;
  localparam int NUM_BYTES = 16;
  localparam int PASSES    = 2;
  localparam int BYTE_W    = 8;
  localparam int SLOT_W    = $clog2(NUM_BYTES);
  localparam int STEP_W    = $clog2(NUM_BYTES * PASSES);
  localparam int CNT_W     = 8;

  // action codes merged by mask; anything but the pass code is a detection
  localparam logic [7:0] CODE_PASS = 8'hA5;
  localparam logic [7:0] CODE_WIPE = 8'h5A;

  typedef struct packed {
    logic              active;
    logic [STEP_W-1:0] step;
  } slotStrobe_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} gateState_t;
endpackage

// File: rtl/result_gate_dp.sv
module result_gate_dp
  import result_gate_pkg::*;
(
  input  slotStrobe_t                        stb,
  input  logic [NUM_BYTES*BYTE_W-1:0]        checkData,
  input  logic [NUM_BYTES*BYTE_W-1:0]        expectData,
  input  logic [NUM_BYTES*PASSES*SLOT_W-1:0] permCfg,
  input  logic [NUM_BYTES*PASSES-1:0]        polCfg,
  output logic                               slotFail
);
  logic [BYTE_W-1:0] chkByte [NUM_BYTES];
  logic [BYTE_W-1:0] expByte [NUM_BYTES];
  logic [SLOT_W-1:0] schedIdx [NUM_BYTES*PASSES];

  genvar g;
  generate
    for (g = 0; g < NUM_BYTES; g++) begin : g_bytes
      assign chkByte[g] = checkData[g*BYTE_W +: BYTE_W];
      assign expByte[g] = expectData[g*BYTE_W +: BYTE_W];
    end
    for (g = 0; g < NUM_BYTES*PASSES; g++) begin : g_sched
      assign schedIdx[g] = permCfg[g*SLOT_W +: SLOT_W];
    end
  endgenerate

  logic [SLOT_W-1:0] curIdx;
  logic              curPol;
  logic              bytesEq;
  logic              cond;
  logic [7:0]        codeA;
  logic [7:0]        codeB;
  logic [7:0]        condMask;
  logic [7:0]        action;

  always_comb begin
    curIdx   = schedIdx[stb.step];
    curPol   = polCfg[stb.step];
    bytesEq  = (chkByte[curIdx] == expByte[curIdx]);
    // polarity 1: cond = equal, A = pass; polarity 0: cond = differ, A = wipe
    cond     = curPol ? bytesEq : ~bytesEq;
    codeA    = curPol ? CODE_PASS : CODE_WIPE;
    codeB    = curPol ? CODE_WIPE : CODE_PASS;
    condMask = {8{cond}};
    action   = (condMask & codeA) | (~condMask & codeB);
    slotFail = stb.active & (action != CODE_PASS);
  end
endmodule

// File: rtl/result_gate_ctrl.sv
module result_gate_ctrl
  import result_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] tamperLimit,
  input  logic             slotFail,
  output slotStrobe_t      stb,
  output logic             busy,
  output logic             done,
  output logic             releaseOut,
  output logic             deleteKey,
  output logic             locked
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_BYTES*PASSES - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};

  gateState_t        state;
  logic [STEP_W-1:0] step;
  logic              runFail;
  logic [CNT_W-1:0]  tamperCount;
  logic [CNT_W-1:0]  nextCount;
  logic [CNT_W-1:0]  effLimit;

  assign stb.active = (state == ST_RUN);
  assign stb.step   = step;
  assign busy       = (state == ST_RUN);
  assign nextCount  = (tamperCount == CNT_MAX) ? tamperCount : tamperCount + 1'b1;
  assign effLimit   = (tamperLimit == '0) ? CNT_W'(1) : tamperLimit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      step        <= '0;
      runFail     <= 1'b0;
      tamperCount <= '0;
      done        <= 1'b0;
      releaseOut  <= 1'b0;
      deleteKey   <= 1'b0;
      locked      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start && !locked) begin
            state      <= ST_RUN;
            step       <= '0;
            runFail    <= 1'b0;
            releaseOut <= 1'b0;
          end
        end
        ST_RUN: begin
          if (slotFail) begin
            runFail     <= 1'b1;
            deleteKey   <= 1'b1;
            tamperCount <= nextCount;
            if (nextCount >= effLimit) locked <= 1'b1;
          end
          if (step == LAST_STEP) begin
            state      <= ST_IDLE;
            done       <= 1'b1;
            releaseOut <= !(runFail || slotFail || deleteKey);
          end else begin
            step <= step + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/result_gate_top.sv
module result_gate_top
  import result_gate_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               start,
  input  logic [NUM_BYTES*BYTE_W-1:0]        checkData,
  input  logic [NUM_BYTES*BYTE_W-1:0]        expectData,
  input  logic [NUM_BYTES*PASSES*SLOT_W-1:0] permCfg,
  input  logic [NUM_BYTES*PASSES-1:0]        polCfg,
  input  logic [CNT_W-1:0]                   tamperLimit,
  output logic                               busy,
  output logic                               done,
  output logic                               releaseOut,
  output logic                               deleteKey,
  output logic                               locked
);
  slotStrobe_t stb;
  logic        slotFail;

  result_gate_dp u_dp (
    .stb        (stb),
    .checkData  (checkData),
    .expectData (expectData),
    .permCfg    (permCfg),
    .polCfg     (polCfg),
    .slotFail   (slotFail)
  );

  result_gate_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .tamperLimit (tamperLimit),
    .slotFail    (slotFail),
    .stb         (stb),
    .busy        (busy),
    .done        (done),
    .releaseOut  (releaseOut),
    .deleteKey   (deleteKey),
    .locked      (locked)
  );
endmodule

// File: rtl/result_gate_sva.sv
module result_gate_sva (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic releaseOut,
  input logic deleteKey,
  input logic locked
);
  a_r2_start_begins_run: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !locked) |=> busy);

  a_r5_delete_sticky: assert property (@(posedge clk) disable iff (!rstN)
    deleteKey |=> deleteKey);

  a_r9_locked_sticky: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);

  a_r9_locked_ignores_start: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !busy) |=> !busy);

  a_r7_release_excludes_delete: assert property (@(posedge clk) disable iff (!rstN)
    releaseOut |-> !deleteKey);

  a_r7_release_rises_on_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(releaseOut) |-> done);

  a_r6_done_ends_run: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
endmodule

bind result_gate_top result_gate_sva u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .releaseOut (releaseOut),
  .deleteKey  (deleteKey),
  .locked     (locked)
);

// File: tb/result_gate_top_bench.sv
`timescale 1ns/1ps
module result_gate_top_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [127:0] checkData = '0;
  logic [127:0] expectData = '0;
  logic [127:0] permCfg = '0;
  logic [31:0]  polCfg = '0;
  logic [7:0]   tamperLimit = 8'd10;
  logic busy, done, releaseOut, deleteKey, locked;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  result_gate_top u_result_gate_top (
    .clk(clk), .rstN(rstN), .start(start), .checkData(checkData),
    .expectData(expectData), .permCfg(permCfg), .polCfg(polCfg),
    .tamperLimit(tamperLimit), .busy(busy), .done(done),
    .releaseOut(releaseOut), .deleteKey(deleteKey), .locked(locked));

  // behavioural reference: a detection is simply a mismatching scheduled byte
  int mStep = 0;
  bit mBusy = 0, mDone = 0, mRel = 0, mDel = 0, mLock = 0, mRunBad = 0;
  int mCount = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mStep = 0; mBusy = 0; mDone = 0; mRel = 0; mDel = 0; mLock = 0;
      mRunBad = 0; mCount = 0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        int idx, lim;
        bit miss;
        idx  = (permCfg >> (mStep * 4)) & 15;
        miss = (checkData[idx*8 +: 8] != expectData[idx*8 +: 8]);
        lim  = (tamperLimit == 0) ? 1 : tamperLimit;
        if (miss) begin
          mRunBad = 1; mDel = 1;
          if (mCount < 255) mCount++;
          if (mCount >= lim) mLock = 1;
        end
        if (mStep == 31) begin
          mBusy = 0; mDone = 1; mRel = !mRunBad && !mDel;
        end else mStep++;
      end else if (start && !mLock) begin
        mBusy = 1; mStep = 0; mRunBad = 0; mRel = 0;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      chk("R2", "busy", busy, mBusy);
      chk("R6", "done", done, mDone);
      chk("R7", "releaseOut", releaseOut, mRel);
      chk("R5", "deleteKey", deleteKey, mDel);
      chk("R9", "locked", locked, mLock);
    end
  end

  function automatic logic [63:0] schedule(int kind);
    logic [63:0] s;
    for (int j = 0; j < 16; j++) begin
      int v;
      case (kind)
        0: v = j;
        1: v = 15 - j;
        default: v = (j == 5) ? 4 : j;
      endcase
      s[j*4 +: 4] = 4'(v);
    end
    return s;
  endfunction

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; start = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runSeq(logic [127:0] perm, logic [31:0] pol, logic [127:0] chkd);
    @(negedge clk);
    permCfg = perm; polCfg = pol; checkData = chkd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (34) @(negedge clk);
  endtask

  logic [127:0] golden;
  logic [127:0] oneBad9;
  logic [127:0] oneBad5;

  initial begin
    golden = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
    expectData = golden;
    oneBad9 = golden ^ (128'h40 << (9*8));
    oneBad5 = golden ^ (128'h01 << (5*8));

    // R1: outputs low during reset
    repeat (2) @(negedge clk);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "releaseOut in reset", releaseOut, 0);
    chk("R1", "deleteKey in reset", deleteKey, 0);
    chk("R1", "locked in reset", locked, 0);
    chk("R1", "done in reset", done, 0);
    rstN = 1'b1;

    // R7: clean result with identity schedule and equality polarity
    runSeq({schedule(0), schedule(0)}, 32'hFFFF_FFFF, golden);
    chk("R7", "release clean identity", releaseOut, 1);

    // R4: polarity mix must not change the verdict
    runSeq({schedule(1), schedule(0)}, 32'h5A3C_0FF0, golden);
    chk("R4", "release clean mixed polarity", releaseOut, 1);
    runSeq({schedule(0), schedule(1)}, 32'h0000_0000, golden);
    chk("R4", "release clean inequality polarity", releaseOut, 1);

    // R5: single mismatch detected under reversed schedule, delete sticky
    runSeq({schedule(1), schedule(1)}, 32'hA5A5_3C3C, oneBad9);
    chk("R5", "deleteKey after mismatch", deleteKey, 1);
    chk("R7", "no release after mismatch", releaseOut, 0);
    runSeq({schedule(0), schedule(0)}, 32'hFFFF_0000, golden);
    chk("R5", "deleteKey stays after clean run", deleteKey, 1);
    chk("R7", "no release once key deleted", releaseOut, 0);

    // R3: byte 5 visited by no slot -> not checked
    doReset();
    tamperLimit = 8'd2;
    runSeq({schedule(2), schedule(2)}, 32'h1234_ABCD, oneBad5);
    chk("R3", "unscheduled byte not checked", releaseOut, 1);
    chk("R3", "no delete for unscheduled byte", deleteKey, 0);

    // R8: only pass 1 visits byte 5
    runSeq({schedule(0), schedule(2)}, 32'hC3C3_9696, oneBad5);
    chk("R8", "pass-1 detection blocks release", releaseOut, 0);
    chk("R8", "pass-1 detection deletes key", deleteKey, 1);
    chk("R9", "one detection below limit 2", locked, 0);

    // R9: second detection reaches limit 2, then start is ignored
    runSeq({schedule(0), schedule(2)}, 32'h0F0F_F0F0, oneBad5);
    chk("R9", "locked at limit", locked, 1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2", "start ignored while locked", busy, 0);

    // R9: limit 0 acts as 1
    doReset();
    tamperLimit = 8'd0;
    runSeq({schedule(1), schedule(0)}, 32'h0000_FFFF, oneBad9);
    chk("R9", "limit zero locks on first detection", locked, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule